// File: doc/BRIEF.md
# Linear scan-chain masking selector

This block sits between the scan-chain outputs of a scan-based design and a test response compactor. It decides, chain by chain, which unload data may reach the compactor. The gating pattern is not stored one bit per chain. A short mask register holds a compressed mask instead, and a fixed linear network over GF(2) expands it into one gating signal per chain. Each gating signal is the XOR of the mask bits that are named by that chain's selector polynomial.

A gate of 1 passes the chain's unload value to the compactor. A gate of 0 forces the chain to zero. A 0 is used to keep unknown captured values away from the signature, or to switch chains off for diagnosis. For chains whose contents do not matter, any gate value is acceptable, so a loaded mask only has to meet the required 0s and 1s. The mask is shifted in serially once per pattern and held during unload. A pass-all input opens every chain. The gated chains are folded onto a few output channels by an XOR tree.

The polynomials are a build-time parameter with one word per chain. Elaboration stops if any two polynomials have more than `MAX_SHARED` mask bits in common.

Top module: `chain_mask_selector`

## Requirements
- R1: While `mask_load_i` is high and `unload_i` is low, each rising clock edge shifts the mask register one place toward its MSB and puts `mask_bit_i` into bit 0. After `MASK_BITS` such edges, the bit presented first sits in bit `MASK_BITS-1`.
- R2: The mask register keeps its value on every edge where `mask_load_i` is low or `unload_i` is high.
- R3: With `pass_all_i` low, `gate_o[j]` equals the XOR over all k of `mask[k] & POLY[j][k]`. In particular, an all-zero mask closes every chain.
- R4: With `pass_all_i` high, every bit of `gate_o` is 1, whatever the mask holds.
- R5: Chain j reaches the compactor as `chain_i[j] & gate_o[j]`. A chain whose gate is 0 has no effect on `chan_o`.
- R6: `chan_o[c]` is the XOR of the gated chains j with `j % NUM_CHAN == c`.
- R7: Asynchronous reset (`rst_ni` low) clears the mask register. As a result, with `pass_all_i` low, `gate_o` and `chan_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mask_load_i | input | 1 | Shift one mask bit in per clock |
| mask_bit_i | input | 1 | Serial mask data |
| unload_i | input | 1 | Scan unload in progress; freezes the mask |
| pass_all_i | input | 1 | Force every gate open |
| chain_i | input | NUM_CHAINS | Scan-chain unload values for this shift cycle |
| gate_o | output | NUM_CHAINS | Per-chain gating signals |
| chan_o | output | NUM_CHAN | Compactor output channels |

## Verification
The shift and hold properties assume that `mask_load_i` and `unload_i` are clean, synchronous levels. The bench changes them only on falling edges, and it asserts `unload_i` only after a complete mask has been shifted in. The linear-map properties assume that the polynomials obey the sharing limit and that mask and chain inputs are 0 or 1. In a two-state run, unknown chain values are stood in for by random data driven on the blocked chains, and the stimulus keeps `pass_all_i` low except in the cases that test it.

// File: rtl/msel_pkg.sv
package msel_pkg;
  // number of set bits in a mask-sized word (mask widths up to 32)
  function automatic int unsigned popcnt(logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/msel_mask_reg.sv
module msel_mask_reg #(
  parameter int unsigned MASK_BITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 bit_i,
  input  logic                 unload_i,
  output logic [MASK_BITS-1:0] mask_o
);
  logic shift_en;
  assign shift_en = load_i & ~unload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_o <= '0;
    else if (shift_en) mask_o <= {mask_o[MASK_BITS-2:0], bit_i};
  end

  assert_shift_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !unload_i) |=> (mask_o[0] == $past(bit_i)) &&
                              (mask_o[MASK_BITS-1:1] == $past(mask_o[MASK_BITS-2:0])));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i || unload_i) |=> $stable(mask_o));
endmodule

// File: rtl/msel_expander.sv
module msel_expander #(
  parameter int unsigned NUM_CHAINS = 8,
  parameter int unsigned MASK_BITS  = 4,
  parameter logic [NUM_CHAINS-1:0][MASK_BITS-1:0] POLY = '0
) (
  input  logic [MASK_BITS-1:0]  mask_i,
  input  logic                  pass_all_i,
  output logic [NUM_CHAINS-1:0] gate_o
);
  logic [NUM_CHAINS-1:0] lin;

  for (genvar j = 0; j < NUM_CHAINS; j++) begin : g_poly
    assign lin[j] = ^(mask_i & POLY[j]);
  end

  assign gate_o = pass_all_i ? '1 : lin;
endmodule

// File: rtl/msel_compactor.sv
module msel_compactor #(
  parameter int unsigned NUM_CHAINS = 8,
  parameter int unsigned NUM_CHAN   = 2
) (
  input  logic [NUM_CHAINS-1:0] chain_i,
  input  logic [NUM_CHAINS-1:0] gate_i,
  output logic [NUM_CHAN-1:0]   chan_o
);
  logic [NUM_CHAINS-1:0] gated;
  assign gated = chain_i & gate_i;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    always_comb begin
      chan_o[c] = 1'b0;
      for (int j = 0; j < NUM_CHAINS; j++)
        if ((j % NUM_CHAN) == c) chan_o[c] = chan_o[c] ^ gated[j];
    end
  end
endmodule

// File: rtl/chain_mask_selector.sv
module chain_mask_selector #(
  parameter int unsigned NUM_CHAINS = 8,
  parameter int unsigned MASK_BITS  = 4,
  parameter int unsigned NUM_CHAN   = 2,
  parameter int unsigned MAX_SHARED = 2,
  parameter logic [NUM_CHAINS-1:0][MASK_BITS-1:0] POLY =
    {4'b1011, 4'b0111, 4'b1100, 4'b1010, 4'b1001, 4'b0110, 4'b0101, 4'b0011}
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mask_load_i,
  input  logic                  mask_bit_i,
  input  logic                  unload_i,
  input  logic                  pass_all_i,
  input  logic [NUM_CHAINS-1:0] chain_i,
  output logic [NUM_CHAINS-1:0] gate_o,
  output logic [NUM_CHAN-1:0]   chan_o
);
  import msel_pkg::*;

  if (MASK_BITS < 2 || MASK_BITS > 32 || MASK_BITS >= NUM_CHAINS) begin : g_bad_dims
    $error("mask width must be 2..32 and below the chain count");
  end

  for (genvar a = 0; a < NUM_CHAINS; a++) begin : g_pa
    for (genvar b = a + 1; b < NUM_CHAINS; b++) begin : g_pb
      if (popcnt(32'(POLY[a] & POLY[b])) > MAX_SHARED) begin : g_overlap
        $error("selector polynomials share too many mask bits");
      end
    end
  end

  logic [MASK_BITS-1:0] mask_q;

  msel_mask_reg #(.MASK_BITS(MASK_BITS)) u_mreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (mask_load_i),
    .bit_i    (mask_bit_i),
    .unload_i (unload_i),
    .mask_o   (mask_q)
  );

  msel_expander #(.NUM_CHAINS(NUM_CHAINS), .MASK_BITS(MASK_BITS), .POLY(POLY)) u_exp (
    .mask_i     (mask_q),
    .pass_all_i (pass_all_i),
    .gate_o     (gate_o)
  );

  msel_compactor #(.NUM_CHAINS(NUM_CHAINS), .NUM_CHAN(NUM_CHAN)) u_cmp (
    .chain_i (chain_i),
    .gate_i  (gate_o),
    .chan_o  (chan_o)
  );

  assert_pass_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_all_i |-> (&gate_o));

  assert_zero_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass_all_i && mask_q == '0) |-> (gate_o == '0));

  assert_closed_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o == '0) |-> (chan_o == '0));
endmodule

// File: tb/sim_chain_mask_selector.sv
`timescale 1ns/1ps
module sim_chain_mask_selector;
  localparam int N = 8, M = 4, C = 2;
  localparam logic [N-1:0][M-1:0] P =
    {4'b1011, 4'b0111, 4'b1100, 4'b1010, 4'b1001, 4'b0110, 4'b0101, 4'b0011};
  // {mask[3:0], chain[7:0]}
  localparam logic [11:0] VEC [6] = '{12'h1_FF, 12'h3_A5, 12'h5_3C,
                                      12'h8_FF, 12'hF_5A, 12'h6_C3};

  logic clk = 0, rst_n = 0, ld = 0, bit_in = 0, unl = 0, pa = 0;
  logic [N-1:0] chain = '0, gate;
  logic [C-1:0] chan;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chain_mask_selector u0 (
    .clk_i(clk), .rst_ni(rst_n), .mask_load_i(ld), .mask_bit_i(bit_in),
    .unload_i(unl), .pass_all_i(pa), .chain_i(chain), .gate_o(gate), .chan_o(chan));

  function automatic logic [N-1:0] exp_gate(logic [M-1:0] m, logic p);
    logic [N-1:0] g;
    for (int j = 0; j < N; j++) g[j] = p | ^(m & P[j]);
    return g;
  endfunction

  function automatic logic [C-1:0] exp_chan(logic [N-1:0] ch, logic [N-1:0] g);
    logic [C-1:0] r = '0;
    for (int j = 0; j < N; j++) r[j % C] ^= ch[j] & g[j];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load_mask(logic [M-1:0] m, logic freeze);
    for (int i = M - 1; i >= 0; i--) begin
      @(negedge clk); ld = 1; bit_in = m[i]; unl = freeze;
    end
    @(negedge clk); ld = 0; unl = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [M-1:0] m;
    logic [N-1:0] g, rnd;
    logic [C-1:0] ref_c;
    chain = '1;
    repeat (3) @(negedge clk);
    chk("R7 gate", 32'(gate), 0);
    chk("R7 chan", 32'(chan), 0);
    rst_n = 1;
    @(negedge clk);

    // table: R1 ordering, R3 linear map, R6 fold
    for (int v = 0; v < 6; v++) begin
      m = VEC[v][11:8];
      load_mask(m, 0);
      chain = VEC[v][7:0];
      #1;
      g = exp_gate(m, 0);
      chk("R1/R3 gate", 32'(gate), 32'(g));
      chk("R6 chan", 32'(chan), 32'(exp_chan(VEC[v][7:0], g)));
    end

    // R2: loads during unload and idle shifting data are ignored
    m = 4'h5;
    load_mask(m, 0);
    load_mask(4'hA, 1);
    chk("R2 unload hold", 32'(gate), 32'(exp_gate(m, 0)));
    @(negedge clk); bit_in = 1; repeat (3) @(negedge clk); bit_in = 0;
    chk("R2 idle hold", 32'(gate), 32'(exp_gate(m, 0)));

    // R4: pass-all
    pa = 1; chain = 8'h96; #1;
    chk("R4 gate", 32'(gate), 32'hFF);
    chk("R4 chan", 32'(chan), 32'(exp_chan(8'h96, 8'hFF)));
    pa = 0;

    // R5: blocked chains carrying junk leave chan unchanged
    for (int t = 0; t < 8; t++) begin
      m = 4'(t + 3);
      load_mask(m, 0);
      g = exp_gate(m, 0);
      chain = 8'h5A; #1;
      ref_c = exp_chan(8'h5A, g);
      rnd = 8'($urandom);
      chain = (8'h5A & g) | (rnd & ~g); #1;
      chk("R5 blocked junk", 32'(chan), 32'(ref_c));
    end

    // R7: zero mask after reset closes all
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; chain = '1; #1;
    chk("R7 post-reset gate", 32'(gate), 0);
    chk("R3 zero mask chan", 32'(chan), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule